// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-event flags and the per-source enables for three timer/counters and turns them into interrupt requests for the CPU. Each timer event reaches it as a one-cycle strobe. A strobe sets the matching flag. Software clears a flag by writing a one to its bit through the register port. A flag also clears by itself when the CPU acknowledges the vector that serves it.

A request goes out for a source only when three things are all true: the global interrupt enable is high, the source's enable bit is set, and its flag is set. Of the active requests, the one with the lowest vector address is presented, together with a valid bit. When timer 1 runs in PWM mode, its overflow flag records the counter turning round at zero, and the ordinary wrap strobe is ignored.

Software reaches both registers through a small bus: a one-bit address, write data, a write enable and combinational read data. Address 0 selects the flag register and address 1 selects the enable register. Both registers use the same bit layout.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, every request output is 0 and the vector valid output is 0.
- R2: A strobe on an event input sets its flag on the next clock. The bit positions are: 7 timer1 overflow, 6 compare 1A, 5 compare 1B, 4 timer2 overflow, 3 capture 1, 2 compare 2, 1 timer0 overflow, 0 compare 0.
- R3: A write to address 0 clears every flag whose write-data bit is 1. A write-data bit of 0 leaves that flag unchanged. Flags written this way never become set.
- R4: A vector acknowledge that arrives while the vector valid output is 1 clears only the flag of the presented source, on the next clock. When valid is 0, an acknowledge has no effect.
- R5: When a hardware set and a clear (a write-one, an acknowledge, or both) reach the same flag in the same cycle, the flag ends up set.
- R6: Request bit i is 1 exactly when the global enable is 1, enable bit i is 1 and flag bit i is 1.
- R7: When the PWM-mode input is 1, flag 7 is set by the reversal-at-bottom strobe and the overflow strobe on bit 7 has no effect. When the PWM-mode input is 0, the roles of the two strobes swap.
- R8: The vector address for source i is 0x014 + 2*i, so compare 0 uses 0x014 and timer0 overflow uses 0x016. With several requests active, the lowest index is presented. The vector valid output is 1 when any request is active. When no request is active, the address is 0.
- R9: A write to address 1 loads the enable register, with the bit positions of R2. A read of either address returns the register contents and has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Hardware event strobes, one per flag bit |
| pwm_mode_i | input | 1 | Timer 1 runs in PWM mode |
| t1_turn_i | input | 1 | Timer 1 reversed direction at zero |
| bus_addr_i | input | 1 | 0 selects the flag register, 1 selects the enable register |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_rdata_o | output | 8 | Read data for the selected register |
| gie_i | input | 1 | Global interrupt enable |
| vec_ack_i | input | 1 | The CPU takes the presented vector |
| irq_o | output | 8 | Request for each source |
| vec_valid_o | output | 1 | At least one request is active |
| vec_addr_o | output | 12 | Address of the highest-priority vector |

## Verification
A flag or enable bit held at the wrong value shows up at the port in the same cycle, either on the read data of its address or on its request line when the other two gate conditions are true. A wrong priority choice shows up at once as a wrong vector address. It also clears the wrong flag one clock after an acknowledge, and that wrong flag then shows up on the next read. The bench compares every output against a behavioural model on every clock, so any divergence is reported in the cycle where it first becomes visible.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int unsigned NSRC        = 8;
    localparam int unsigned T1_OVF_BIT  = 7;
    localparam int unsigned VAW         = 12;
    localparam logic [11:0] VEC_BASE    = 12'h014;
    localparam logic [11:0] VEC_STEP    = 12'h002;

    typedef struct packed {
        logic [NSRC-1:0] flg;
        logic [NSRC-1:0] ena;
    } tic_regs_t;
endpackage

// File: rtl/tic_flag_bank.sv
module tic_flag_bank #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] flg_q,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] wclr_i,
    input  logic [N-1:0] aclr_i,
    output logic [N-1:0] flg_d
);
    // Per bit: a set beats any clear, and a clear beats holding the old value.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            if (set_i[i])
                flg_d[i] = 1'b1;
            else if (wclr_i[i] || aclr_i[i])
                flg_d[i] = 1'b0;
            else
                flg_d[i] = flg_q[i];
        end
    end
endmodule

// File: rtl/tic_prio_enc.sv
module tic_prio_enc #(
    parameter int unsigned N        = 8,
    parameter int unsigned AW       = 12,
    parameter logic [AW-1:0] BASE   = 12'h014,
    parameter logic [AW-1:0] STEP   = 12'h002,
    localparam int unsigned IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o,
    output logic [AW-1:0] addr_o
);
    always_comb begin
        idx_o = '0;
        // Scan downward so that the lowest active index is the one kept.
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign valid_o = |req_i;
    assign addr_o  = valid_o ? (BASE + STEP * AW'(idx_o)) : '0;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            pwm_mode_i,
    input  logic            t1_turn_i,
    input  logic            bus_addr_i,
    input  logic [NSRC-1:0] bus_wdata_i,
    input  logic            bus_we_i,
    output logic [NSRC-1:0] bus_rdata_o,
    input  logic            gie_i,
    input  logic            vec_ack_i,
    output logic [NSRC-1:0] irq_o,
    output logic            vec_valid_o,
    output logic [VAW-1:0]  vec_addr_o
);
    localparam int unsigned IW = $clog2(NSRC);

    tic_regs_t       regs_d, regs_q;
    logic [NSRC-1:0] set_v, wclr_v, aclr_v, flg_nxt;
    logic [NSRC-1:0] flg_q, ena_q;
    logic [IW-1:0]   sel_idx;

    assign flg_q = regs_q.flg;
    assign ena_q = regs_q.ena;

    always_comb begin
        set_v = evt_i;
        set_v[T1_OVF_BIT] = pwm_mode_i ? t1_turn_i : evt_i[T1_OVF_BIT];
        wclr_v = (bus_we_i && !bus_addr_i) ? bus_wdata_i : '0;
        aclr_v = '0;
        if (vec_ack_i && vec_valid_o) aclr_v[sel_idx] = 1'b1;
    end

    tic_flag_bank #(.N(NSRC)) u_bank (
        .flg_q  (flg_q),
        .set_i  (set_v),
        .wclr_i (wclr_v),
        .aclr_i (aclr_v),
        .flg_d  (flg_nxt)
    );

    assign irq_o = {NSRC{gie_i}} & ena_q & flg_q;

    tic_prio_enc #(
        .N    (NSRC),
        .AW   (VAW),
        .BASE (VEC_BASE),
        .STEP (VEC_STEP)
    ) u_prio (
        .req_i   (irq_o),
        .valid_o (vec_valid_o),
        .idx_o   (sel_idx),
        .addr_o  (vec_addr_o)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.flg = flg_nxt;
        if (bus_we_i && bus_addr_i) regs_d.ena = bus_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata_o = bus_addr_i ? ena_q : flg_q;
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
    import tic_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] evt_i,
    input logic            pwm_mode_i,
    input logic            t1_turn_i,
    input logic            bus_addr_i,
    input logic [NSRC-1:0] bus_wdata_i,
    input logic            bus_we_i,
    input logic            gie_i,
    input logic [NSRC-1:0] irq_o,
    input logic            vec_valid_o,
    input logic [VAW-1:0]  vec_addr_o,
    input logic [NSRC-1:0] flg_q
);
    logic [NSRC-1:0] hw_set;
    always_comb begin
        hw_set = evt_i;
        hw_set[T1_OVF_BIT] = pwm_mode_i ? t1_turn_i : evt_i[T1_OVF_BIT];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R2 and R5: a hardware set always lands, whatever clear arrives with it
        p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> flg_q[i]);
        // R3: a write-one with no set leaves the flag cleared
        p_wr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we_i && !bus_addr_i && bus_wdata_i[i] && !hw_set[i]) |=> !flg_q[i]);
    end

    // R7: in PWM mode the plain overflow strobe cannot raise flag 7 from clear
    p_pwm_ignores_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_i && !t1_turn_i && !flg_q[T1_OVF_BIT]) |=> !flg_q[T1_OVF_BIT]);

    // R6: no request leaves while the global enable is low
    p_irq_needs_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> gie_i);

    // R8: a presented vector always lies inside the table
    p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_addr_o >= VEC_BASE &&
                         vec_addr_o <= VEC_BASE + VEC_STEP * VAW'(NSRC - 1)));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .pwm_mode_i  (pwm_mode_i),
    .t1_turn_i   (t1_turn_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_we_i    (bus_we_i),
    .gie_i       (gie_i),
    .irq_o       (irq_o),
    .vec_valid_o (vec_valid_o),
    .vec_addr_o  (vec_addr_o),
    .flg_q       (flg_q)
);

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        pwm_mode_i = 1'b0;
    logic        t1_turn_i = 1'b0;
    logic        bus_addr_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic        bus_we_i = 1'b0;
    logic [7:0]  bus_rdata_o;
    logic        gie_i = 1'b0;
    logic        vec_ack_i = 1'b0;
    logic [7:0]  irq_o;
    logic        vec_valid_o;
    logic [11:0] vec_addr_o;

    int n_vec = 0;
    int n_bad = 0;
    bit m_flg[8];
    bit m_ena[8];

    always #10 clk = ~clk;

    tmr_irq_ctrl u_dut (.*);

    function automatic int pick();
        for (int i = 0; i < 8; i++)
            if (gie_i && m_ena[i] && m_flg[i]) return i;
        return -1;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        int p;
        int ir;
        int rd;
        p = pick();
        ir = 0;
        rd = 0;
        for (int i = 0; i < 8; i++) begin
            if (gie_i && m_ena[i] && m_flg[i]) ir |= (1 << i);
            if (bus_addr_i ? m_ena[i] : m_flg[i]) rd |= (1 << i);
        end
        chk(tag, "irq", int'(irq_o), ir);
        chk(tag, "valid", int'(vec_valid_o), (p >= 0) ? 1 : 0);
        chk(tag, "vector", int'(vec_addr_o), (p >= 0) ? (32'h14 + 2 * p) : 0);
        chk(tag, "rdata", int'(bus_rdata_o), rd);
    endtask

    // Inputs are already driven; compare, let the clock rise, then advance the model.
    task automatic step(string tag);
        int p;
        bit s;
        bit c;
        #1 compare(tag);
        p = pick();
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            s = (i == 7) ? (pwm_mode_i ? t1_turn_i : evt_i[7]) : evt_i[i];
            c = (bus_we_i && !bus_addr_i && bus_wdata_i[i]) || (vec_ack_i && p == i);
            if (s) m_flg[i] = 1'b1;
            else if (c) m_flg[i] = 1'b0;
        end
        if (bus_we_i && bus_addr_i)
            for (int i = 0; i < 8; i++) m_ena[i] = bus_wdata_i[i];
        @(negedge clk);
        evt_i = '0; t1_turn_i = 1'b0; bus_we_i = 1'b0; vec_ack_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic wr(string tag, bit a, logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        step(tag);
    endtask

    task automatic idle(string tag, bit a);
        bus_addr_i = a;
        step(tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_flg[i] = 0; m_ena[i] = 0; end
        repeat (2) @(negedge clk);
        // R1: values straight after reset
        idle("R1", 1'b0);
        idle("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1", 1'b0);
        idle("R1", 1'b1);

        // R2: each strobe sets its own flag
        for (int i = 0; i < 8; i++) begin
            evt_i = 8'(1 << i);
            idle("R2", 1'b0);
            idle("R2", 1'b0);
        end
        // R3: write-one clears, write-zero holds
        wr("R3", 1'b0, 8'h00);
        idle("R3", 1'b0);
        wr("R3", 1'b0, 8'h0F);
        idle("R3", 1'b0);
        wr("R3", 1'b0, 8'hF0);
        idle("R3", 1'b0);

        // R9: enable register writes and side-effect-free reads
        wr("R9", 1'b1, 8'hA5);
        idle("R9", 1'b1);
        idle("R9", 1'b0);
        idle("R9", 1'b1);
        wr("R9", 1'b1, 8'h03);
        idle("R9", 1'b1);

        // R6: requests gated by all three conditions
        evt_i = 8'h07;
        idle("R6", 1'b0);
        idle("R6", 1'b0);
        gie_i = 1'b1;
        idle("R6", 1'b0);
        wr("R6", 1'b1, 8'hFF);
        idle("R6", 1'b0);
        gie_i = 1'b0;
        idle("R6", 1'b0);
        gie_i = 1'b1;

        // R8: lowest active index presented; 0x014 and 0x016 for bits 0 and 1
        evt_i = 8'hC2;
        idle("R8", 1'b0);
        idle("R8", 1'b0);
        wr("R8", 1'b1, 8'hFE);
        idle("R8", 1'b0);
        wr("R8", 1'b1, 8'h80);
        idle("R8", 1'b0);
        wr("R8", 1'b1, 8'hFF);

        // R4: acknowledges pop vectors one by one
        for (int k = 0; k < 7; k++) begin
            vec_ack_i = 1'b1;
            idle("R4", 1'b0);
        end
        idle("R4", 1'b0);
        vec_ack_i = 1'b1;
        idle("R4", 1'b0);
        // R4: an acknowledge while nothing is valid
        evt_i = 8'h10;
        idle("R4", 1'b0);
        gie_i = 1'b0;
        vec_ack_i = 1'b1;
        idle("R4", 1'b0);
        gie_i = 1'b1;
        idle("R4", 1'b0);

        // R5: set beats simultaneous clear
        evt_i = 8'h10; vec_ack_i = 1'b1;
        wr("R5", 1'b0, 8'h10);
        idle("R5", 1'b0);
        evt_i = 8'h01;
        idle("R5", 1'b0);
        evt_i = 8'h01; vec_ack_i = 1'b1;
        idle("R5", 1'b0);
        wr("R5", 1'b0, 8'hFF);

        // R7: source of flag 7 depends on PWM mode
        pwm_mode_i = 1'b1;
        evt_i = 8'h80;
        idle("R7", 1'b0);
        t1_turn_i = 1'b1;
        idle("R7", 1'b0);
        wr("R7", 1'b0, 8'h80);
        pwm_mode_i = 1'b0;
        t1_turn_i = 1'b1;
        idle("R7", 1'b0);
        evt_i = 8'h80;
        idle("R7", 1'b0);
        wr("R7", 1'b0, 8'hFF);

        // Mixed traffic against the model
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                evt_i = lf[7:0] & {lf[9], lf[11], lf[8], lf[15], lf[12], lf[10], lf[14], lf[13]};
                pwm_mode_i = lf[3];
                t1_turn_i = lf[5];
                gie_i = lf[6] | lf[2];
                vec_ack_i = lf[1];
                bus_addr_i = lf[4];
                bus_we_i = lf[0] & lf[9];
                bus_wdata_i = {lf[15:12], lf[11:8]} ^ lf[7:0];
                step("R5");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule